// File: doc/BRIEF.md
# Channel busy ratio monitor

This block keeps five free-running activity counters for a radio channel and turns them into per-interval statistics. One counter advances every clock. The other four advance on clocks where their level input is high: control-channel busy, extension-channel busy, receive-frame activity and transmit-frame activity. Rather than wrapping, the counters halve together when the cycle counter reaches its ceiling. Halving all of them keeps their ratios intact, but a difference taken across such an event means nothing.

A sample request arrives on a valid/ready pair. When a sample is accepted, the block subtracts the stored snapshot from the live counters to get the five deltas, then stores the live values as the new snapshot. It then works out how busy the extension channel was, as a percentage of the time the control channel was clear, using a sequential restoring divider. `smp_ready_o` is low from acceptance until the result is complete. A request made while ready is low is not taken and has no effect, and the block applies no other back-pressure. `res_done_o` pulses for one clock when the results are complete. The deltas and the valid flag change on acceptance, the percentage changes on completion, and all of them hold until the next accepted sample.

Top module: `chan_busy_mon`

## Requirements
- R1: After reset all counters are zero. The cycle counter adds one on every clock. Each activity counter adds one on every clock where its input is high, so no activity counter ever exceeds the cycle counter.
- R2: On a clock where the cycle counter holds its all-ones maximum, all five counters shift right by one bit and nothing is added on that clock.
- R3: A sample is invalid if it is the first one accepted after reset, or if the live cycle count is below the stored snapshot. An invalid sample gives `res_ok_o`=0, all five deltas 0 and a percentage of 0.
- R4: For a valid sample, each delta output equals the live counter minus its snapshot, and `res_ok_o`=1.
- R5: The clear time is the cycle delta minus the control-busy delta when the cycle delta is strictly larger, and zero otherwise. The percentage is the floor of the extension-busy delta times 100 divided by the clear time, clamped to 100.
- R6: For a valid sample with zero clear time, the percentage is 100.
- R7: Every accepted sample, valid or not, replaces the snapshot with the live counter values.
- R8: `smp_ready_o` is high after reset. It is low from the clock after an acceptance that starts a division until `res_done_o` pulses. A request made while it is low is ignored and leaves the outputs and the snapshot unchanged.
- R9: `res_done_o` is a single-clock pulse for each accepted sample, and `busy_pct_o` never exceeds 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_busy_i | input | 1 | Control channel busy level |
| ext_busy_i | input | 1 | Extension channel busy level |
| rx_frame_i | input | 1 | Receive frame activity level |
| tx_frame_i | input | 1 | Transmit frame activity level |
| smp_valid_i | input | 1 | Sample request |
| smp_ready_o | output | 1 | Sample request can be accepted |
| res_done_o | output | 1 | One-clock pulse: results complete |
| res_ok_o | output | 1 | Last sample was valid |
| d_cycles_o | output | CNT_W | Cycle delta |
| d_ctl_o | output | CNT_W | Control busy delta |
| d_ext_o | output | CNT_W | Extension busy delta |
| d_rx_o | output | CNT_W | Receive frame delta |
| d_tx_o | output | CNT_W | Transmit frame delta |
| busy_pct_o | output | 7 | Extension busy percentage, 0 to 100 |

## Verification
The assertions check the following on every clock:
- the halving step when the cycle counter reaches its maximum;
- activity counters never passing the cycle counter;
- zeroed outputs on an invalid result;
- the percentage bound;
- outputs and snapshot holding while a request is refused;
- the snapshot tracking the live count on acceptance.

The directed scenarios are needed for the rest. Only they can show that the delta values, the clear-time arithmetic, the clamp and the zero-clear case give the right numbers for known activity patterns. Only they can show that the sample which spans a counter halving is flagged invalid and that the sample after it is valid again.

// File: rtl/chan_busy_pkg.sv
package chan_busy_pkg;
  localparam int NUM_CNT  = 5;
  localparam int IDX_CYC  = 0;
  localparam int IDX_CTL  = 1;
  localparam int IDX_EXT  = 2;
  localparam int IDX_RX   = 3;
  localparam int IDX_TX   = 4;
  localparam int PCT_W    = 7;
  localparam int PCT_FULL = 100;
endpackage

// File: rtl/chan_busy_counters.sv
module chan_busy_counters
  import chan_busy_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CNT-1:0]                act_i,
  output logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic                          halve;

  // the cycle counter leads; activity counters never exceed it
  assign halve = (cnt_q[IDX_CYC] == CNT_MAX);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q[g] <= '0;
      else if (halve)     cnt_q[g] <= cnt_q[g] >> 1;
      else if (act_i[g])  cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/chan_busy_div.sv
module chan_busy_div #(
  parameter int NUM_W = 39,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CW = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [CW-1:0]    step_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   rem_sh, rem_nx;
  logic             fits;

  // one restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    rem_sh = {rem_q, num_q[NUM_W-1]};
    fits   = (rem_sh >= {1'b0, den_q});
    rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      num_q  <= num_i;
      den_q  <= den_i;
      rem_q  <= '0;
      step_q <= CW'(NUM_W - 1);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      num_q <= {num_q[NUM_W-2:0], fits};
      rem_q <= rem_nx[DEN_W-1:0];
      if (step_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_q - 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = num_q;
endmodule

// File: rtl/chan_busy_mon.sv
module chan_busy_mon
  import chan_busy_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_busy_i,
  input  logic             ext_busy_i,
  input  logic             rx_frame_i,
  input  logic             tx_frame_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  output logic             res_done_o,
  output logic             res_ok_o,
  output logic [CNT_W-1:0] d_cycles_o,
  output logic [CNT_W-1:0] d_ctl_o,
  output logic [CNT_W-1:0] d_ext_o,
  output logic [CNT_W-1:0] d_rx_o,
  output logic [CNT_W-1:0] d_tx_o,
  output logic [PCT_W-1:0] busy_pct_o
);
  localparam int NUM_W = CNT_W + PCT_W;

  logic [NUM_CNT-1:0]            act;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] snap_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] dlt_c;
  logic [NUM_CNT-1:0][CNT_W-1:0] dlt_q;
  logic                          have_prev_q;
  logic                          ok_c, ok_q;
  logic [CNT_W-1:0]              clear_c;
  logic [NUM_W-1:0]              num_c;
  logic                          accept, div_start, div_busy, div_done;
  logic [NUM_W-1:0]              div_quot;
  logic [PCT_W-1:0]              pct_q;
  logic                          done_q;

  assign act[IDX_CYC] = 1'b1;
  assign act[IDX_CTL] = ctl_busy_i;
  assign act[IDX_EXT] = ext_busy_i;
  assign act[IDX_RX]  = rx_frame_i;
  assign act[IDX_TX]  = tx_frame_i;

  chan_busy_counters #(.CNT_W(CNT_W)) u_counters (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .cnt_o (cnt_q)
  );

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) dlt_c[i] = cnt_q[i] - snap_q[i];
    ok_c    = have_prev_q && (cnt_q[IDX_CYC] >= snap_q[IDX_CYC]);
    clear_c = (dlt_c[IDX_CYC] > dlt_c[IDX_CTL]) ?
              (dlt_c[IDX_CYC] - dlt_c[IDX_CTL]) : '0;
    num_c   = NUM_W'(dlt_c[IDX_EXT]) * NUM_W'(PCT_FULL);
  end

  assign smp_ready_o = !div_busy && !div_done;
  assign accept      = smp_valid_i && smp_ready_o;
  assign div_start   = accept && ok_c && (clear_c != '0);

  chan_busy_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .num_i   (num_c),
    .den_i   (clear_c),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q      <= '0;
      dlt_q       <= '0;
      have_prev_q <= 1'b0;
      ok_q        <= 1'b0;
      pct_q       <= '0;
      done_q      <= 1'b0;
    end else if (accept) begin
      snap_q      <= cnt_q;
      have_prev_q <= 1'b1;
      ok_q        <= ok_c;
      dlt_q       <= ok_c ? dlt_c : '0;
      if (!ok_c) begin
        pct_q  <= '0;
        done_q <= 1'b1;
      end else if (clear_c == '0) begin
        pct_q  <= PCT_W'(PCT_FULL);
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else if (div_done) begin
      pct_q  <= (div_quot > NUM_W'(PCT_FULL)) ? PCT_W'(PCT_FULL)
                                              : div_quot[PCT_W-1:0];
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign res_done_o = done_q;
  assign res_ok_o   = ok_q;
  assign d_cycles_o = dlt_q[IDX_CYC];
  assign d_ctl_o    = dlt_q[IDX_CTL];
  assign d_ext_o    = dlt_q[IDX_EXT];
  assign d_rx_o     = dlt_q[IDX_RX];
  assign d_tx_o     = dlt_q[IDX_TX];
  assign busy_pct_o = pct_q;
endmodule

// File: rtl/chan_busy_mon_chk.sv
module chan_busy_mon_chk
  import chan_busy_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
  input logic [CNT_W-1:0]              snap_cyc,
  input logic                          smp_valid,
  input logic                          smp_ready,
  input logic                          done,
  input logic                          ok,
  input logic [CNT_W-1:0]              d_cyc,
  input logic [CNT_W-1:0]              d_ctl,
  input logic [CNT_W-1:0]              d_ext,
  input logic [CNT_W-1:0]              d_rx,
  input logic [CNT_W-1:0]              d_tx,
  input logic [PCT_W-1:0]              pct
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_sat_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[IDX_CYC] == CNT_MAX) |=> (cnt[IDX_CYC] == (CNT_MAX >> 1)));

  p_ctl_le_cyc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[IDX_CTL] <= cnt[IDX_CYC]) && (cnt[IDX_EXT] <= cnt[IDX_CYC]));

  p_invalid_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (d_cyc == '0 && d_ctl == '0 && d_ext == '0 &&
                       d_rx == '0 && d_tx == '0 && pct == '0));

  p_pct_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pct <= PCT_W'(PCT_FULL));

  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> smp_ready);

  p_refused_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> ($stable(d_cyc) && $stable(snap_cyc)));

  p_snap_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (snap_cyc == $past(cnt[IDX_CYC])));
endmodule

bind chan_busy_mon chan_busy_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt       (cnt_q),
  .snap_cyc  (snap_q[0]),
  .smp_valid (smp_valid_i),
  .smp_ready (smp_ready_o),
  .done      (res_done_o),
  .ok        (res_ok_o),
  .d_cyc     (d_cycles_o),
  .d_ctl     (d_ctl_o),
  .d_ext     (d_ext_o),
  .d_rx      (d_rx_o),
  .d_tx      (d_tx_o),
  .pct       (busy_pct_o)
);

// File: tb/chan_busy_mon_bench.sv
module chan_busy_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_i = 0, ext_i = 0, rx_i = 0, tx_i = 0, smp_valid = 0;
  logic smp_ready, res_done, res_ok;
  logic [CNT_W-1:0] d_cyc, d_ctl, d_ext, d_rx, d_tx;
  logic [6:0] pct;

  int checks = 0;
  int errors = 0;
  int bc[5];
  int bsnap[5];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_busy_mon #(.CNT_W(CNT_W)) u_chan_busy_mon (
    .clk(clk), .rst_n(rst_n),
    .ctl_busy_i(ctl_i), .ext_busy_i(ext_i), .rx_frame_i(rx_i), .tx_frame_i(tx_i),
    .smp_valid_i(smp_valid), .smp_ready_o(smp_ready),
    .res_done_o(res_done), .res_ok_o(res_ok),
    .d_cycles_o(d_cyc), .d_ctl_o(d_ctl), .d_ext_o(d_ext), .d_rx_o(d_rx), .d_tx_o(d_tx),
    .busy_pct_o(pct)
  );

  // bench-side activity tally (never wraps)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) bc[i] <= 0;
    end else begin
      bc[0] <= bc[0] + 1;
      bc[1] <= bc[1] + int'(ctl_i);
      bc[2] <= bc[2] + int'(ext_i);
      bc[3] <= bc[3] + int'(rx_i);
      bc[4] <= bc[4] + int'(tx_i);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold_level(ref logic sig, input int n);
    @(negedge clk); sig = 1'b1;
    repeat (n) @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!res_done && n < 100) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, int'(res_done), 1);
  endtask

  // accept one sample and compare with values derived from the requirements
  task automatic do_sample(input bit exp_ok, input string tag);
    int d[5];
    int clr, e_pct;
    @(negedge clk);
    chk({tag, " R8 ready before request"}, int'(smp_ready), 1);
    for (int i = 0; i < 5; i++) begin d[i] = bc[i] - bsnap[i]; bsnap[i] = bc[i]; end
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    wait_done(tag);
    if (!exp_ok) for (int i = 0; i < 5; i++) d[i] = 0;
    clr   = (d[0] > d[1]) ? d[0] - d[1] : 0;
    e_pct = !exp_ok ? 0 : (clr == 0) ? 100 : ((d[2]*100/clr > 100) ? 100 : d[2]*100/clr);
    chk({tag, " R3/R4 ok flag"}, int'(res_ok), int'(exp_ok));
    chk({tag, " R4 cycle delta"}, int'(d_cyc), d[0]);
    chk({tag, " R4 ctl delta"},   int'(d_ctl), d[1]);
    chk({tag, " R4 ext delta"},   int'(d_ext), d[2]);
    chk({tag, " R4 rx delta"},    int'(d_rx),  d[3]);
    chk({tag, " R4 tx delta"},    int'(d_tx),  d[4]);
    chk({tag, " R5 percentage"},  int'(pct),   e_pct);
    @(negedge clk);
    chk({tag, " R9 done one clock"}, int'(res_done), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 ready after reset", int'(smp_ready), 1);
    chk("R9 done after reset",  int'(res_done), 0);
    chk("R3 ok after reset",    int'(res_ok), 0);
    chk("R9 pct after reset",   int'(pct), 0);
  endtask

  task automatic t_first_invalid();
    repeat (5) @(negedge clk);
    do_sample(1'b0, "R3 first sample");
  endtask

  task automatic t_activity();
    hold_level(ctl_i, 20);
    fork hold_level(ext_i, 15); hold_level(rx_i, 7); join
    hold_level(tx_i, 5);
    do_sample(1'b1, "R1 R5 mixed activity");
    chk("R1 ctl count", int'(d_ctl), 20);
    chk("R1 tx count",  int'(d_tx), 5);
  endtask

  task automatic t_clamp();
    fork hold_level(ctl_i, 100); hold_level(ext_i, 100); join
    do_sample(1'b1, "R5 clamp");
    chk("R5 clamp to 100", int'(pct), 100);
  endtask

  task automatic t_refused();
    int d0;
    repeat (4) @(negedge clk);
    d0 = bc[0] - bsnap[0];
    for (int i = 0; i < 5; i++) bsnap[i] = bc[i];
    smp_valid = 1'b1;
    @(negedge clk);
    chk("R8 ready low while dividing", int'(smp_ready), 0);
    repeat (3) @(negedge clk);       // request held while refused
    smp_valid = 1'b0;
    wait_done("R8 dividing sample");
    chk("R8 cycle delta of accepted sample", int'(d_cyc), d0);
    repeat (6) @(negedge clk);
    do_sample(1'b1, "R8 R7 after refused requests");
  endtask

  task automatic t_ctl_full();
    @(negedge clk); ctl_i = 1'b1;
    do_sample(1'b1, "R6 lead-in");
    repeat (8) @(negedge clk);
    do_sample(1'b1, "R6 zero clear");
    chk("R6 pct with no clear time", int'(pct), 100);
    ctl_i = 1'b0;
  endtask

  task automatic t_saturate();
    chk("R2 headroom before saturation", int'(bc[0] < 990), 1);
    while (bc[0] < 990) @(negedge clk);
    do_sample(1'b1, "R2 before saturation");
    repeat (60) @(negedge clk);
    do_sample(1'b0, "R2 R3 across halving");
    repeat (30) @(negedge clk);
    do_sample(1'b1, "R7 after invalid sample");
  endtask

  initial begin
    for (int i = 0; i < 5; i++) bsnap[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_invalid();
    t_activity();
    t_clamp();
    t_refused();
    t_ctl_full();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule